// File: doc/BRIEF.md
# Multi-Level Interrupt Dispatch Unit

This block decides, on each request strobe, whether a pending interrupt at a given level may be taken, and if so produces every processor-state update that taking it implies. These are the saved program counter and status word, the cause code, the new status word, the handler address and a classification of the event. The processor keeps its own architectural registers. It presents the current PC, status word, vector base, interrupt-set and interrupt-enable words and one mask per level, and it commits the write strobes this unit returns.

Levels above one are dispatched directly to a per-level handler address, and the interrupted context is saved in registers indexed by that level. A level-one interrupt is instead turned into a general exception. It becomes a user or kernel exception depending on the status word, or a double exception when an exception is already in progress. Handler addresses are formed from fixed offsets, added either to the live vector-base input or to a fixed default base, depending on a parameter.

All results are registered. The strobe and every write it qualifies appear together in the cycle after the request is sampled.

Top module: `dispatch_unit`

## Requirements
- R1: A request is taken only when its level is strictly greater than the interrupt-level field, status bits [3:0].
- R2: A request whose level exceeds the configured level count (default 6) is never taken.
- R3: A request is taken only when the AND of its level's mask, the set word and the enable word is nonzero.
- R4: For a taken level L above 1, the PC is written to saved-PC destination L, and the status word is written to saved-status index L.
- R5: For a taken level L above 1, the new status word has bits [3:0] equal to L and the exception-mode bit (bit 4) set, with all other bits unchanged. The kind code is 0.
- R6: For a taken level L above 1, the next PC is the base plus 0x100 plus L*0x40.
- R7: For a taken level-1 request, the cause output is written with code 4, and the new status word is the old one with bit 4 set. No saved-status write occurs.
- R8: A level-1 request with bit 4 already set is a double exception with kind code 3 and next PC base+0x3C0. The PC is saved to destination 0 (the double-exception PC) when that register is configured, and to destination 1 otherwise.
- R9: A level-1 request with bit 4 clear saves the PC to destination 1. If user-mode bit 5 is set, the kind code is 2 and the next PC is base+0x340. Otherwise the kind code is 1 and the next PC is base+0x300.
- R10: With relocation enabled, the base is the current vector-base input. With relocation disabled, the base is the fixed default base.
- R11: The taken strobe is high for exactly the one cycle after each qualifying request is sampled, and all write strobes of that event are valid in that same cycle.
- R12: When nothing qualifies, no write strobe is raised, the next PC equals the PC sampled in that cycle, and the new status word equals the status word sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evalReq | input | 1 | Evaluate the pending level this cycle |
| pendLevel | input | LVL_W | Pending interrupt level |
| statusIn | input | PS_W | Current status word |
| pcIn | input | PC_W | Current program counter |
| vecBase | input | PC_W | Current vector-base register |
| intSet | input | NINT | Interrupt-set word |
| intEnable | input | NINT | Interrupt-enable word |
| levelMask | input | 2**LVL_W x NINT | Per-level interrupt masks |
| excTaken | output | 1 | Exception-taken pulse |
| excKind | output | 2 | 0 high level, 1 kernel, 2 user, 3 double |
| nextPc | output | PC_W | Next PC |
| newStatus | output | PS_W | Next status word |
| savePcWe | output | 1 | Saved-PC write strobe |
| savePcDst | output | LVL_W | Saved-PC destination (0 = double-exception PC) |
| savePcVal | output | PC_W | Saved-PC value |
| savePsWe | output | 1 | Saved-status write strobe |
| savePsIdx | output | LVL_W | Saved-status level index |
| savePsVal | output | PS_W | Saved-status value |
| causeWe | output | 1 | Cause write strobe |
| causeVal | output | CAUSE_W | Cause value |

## Verification
Two functions meet in one cycle when a level-one request arrives while the exception-mode bit is still set. The double-exception path must then win over the user or kernel classification, while the cause write and the exception-mode update of ordinary level-one handling still happen. The bench provokes this both with the user-mode bit set and with it clear, and it mixes such cases into long random runs that also vary the vector base. The reference model predicts each output field independently every cycle. A destination, vector or kind that follows the user bit instead of the double-exception rule shows up as a miscompare.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  typedef enum logic [1:0] {
    KIND_HIGH   = 2'd0,
    KIND_KERNEL = 2'd1,
    KIND_USER   = 2'd2,
    KIND_DOUBLE = 2'd3
  } excKind_e;

  // Strobes from the decision logic to the datapath
  typedef struct packed {
    logic take;      // request qualifies
    logic hiLevel;   // level above one: direct vector
    logic dbl;       // level one while already in exception mode
    logic user;      // level one from user mode
  } dispCtrl_t;

endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
#(
  parameter int LVL_W      = 4,
  parameter int PS_W       = 8,
  parameter int NINT       = 16,
  parameter int NUM_LEVELS = 6
) (
  input  logic                               evalReq,
  input  logic [LVL_W-1:0]                   pendLevel,
  input  logic [PS_W-1:0]                    statusIn,
  input  logic [NINT-1:0]                    intSet,
  input  logic [NINT-1:0]                    intEnable,
  input  logic [(2**LVL_W)-1:0][NINT-1:0]    levelMask,
  output dispCtrl_t                          ctrl
);

  localparam int EXCM_BIT = LVL_W;
  localparam int UM_BIT   = LVL_W + 1;

  logic [LVL_W-1:0] curLevel;
  logic             aboveCur;
  logic             inRange;
  logic             srcLive;

  assign curLevel = statusIn[LVL_W-1:0];
  assign aboveCur = pendLevel > curLevel;
  assign inRange  = pendLevel <= LVL_W'(NUM_LEVELS);
  assign srcLive  = |(levelMask[pendLevel] & intSet & intEnable);

  always_comb begin
    ctrl.take    = evalReq && aboveCur && inRange && srcLive;
    ctrl.hiLevel = pendLevel > LVL_W'(1);
    ctrl.dbl     = !ctrl.hiLevel && statusIn[EXCM_BIT];
    ctrl.user    = !ctrl.hiLevel && !statusIn[EXCM_BIT] && statusIn[UM_BIT];
  end

endmodule

// File: rtl/dispatch_dp.sv
module dispatch_dp
  import dispatch_pkg::*;
#(
  parameter int          LVL_W       = 4,
  parameter int          PS_W        = 8,
  parameter int          PC_W        = 32,
  parameter int          CAUSE_W     = 6,
  parameter bit          RELOCATE    = 1'b1,
  parameter bit          HAS_DEPC    = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000,
  parameter int          HI_OFF      = 'h100,
  parameter int          HI_STRIDE   = 'h40,
  parameter int          KERNEL_OFF  = 'h300,
  parameter int          USER_OFF    = 'h340,
  parameter int          DOUBLE_OFF  = 'h3C0,
  parameter int          L1_CAUSE    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dispCtrl_t            ctrl,
  input  logic [LVL_W-1:0]     pendLevel,
  input  logic [PS_W-1:0]      statusIn,
  input  logic [PC_W-1:0]      pcIn,
  input  logic [PC_W-1:0]      vecBase,
  output logic                 excTaken,
  output logic [1:0]           excKind,
  output logic [PC_W-1:0]      nextPc,
  output logic [PS_W-1:0]      newStatus,
  output logic                 savePcWe,
  output logic [LVL_W-1:0]     savePcDst,
  output logic [PC_W-1:0]      savePcVal,
  output logic                 savePsWe,
  output logic [LVL_W-1:0]     savePsIdx,
  output logic [PS_W-1:0]      savePsVal,
  output logic                 causeWe,
  output logic [CAUSE_W-1:0]   causeVal
);

  localparam int EXCM_BIT = LVL_W;
  localparam logic [LVL_W-1:0] DST_DOUBLE = HAS_DEPC ? LVL_W'(0) : LVL_W'(1);

  logic [PC_W-1:0] vecRoot;
  logic [PC_W-1:0] vecOff;
  logic [PC_W-1:0] vecAddr;
  logic [PS_W-1:0] psHi;
  logic [PS_W-1:0] psL1;
  excKind_e        kindNow;
  logic [LVL_W-1:0] pcDstNow;

  generate
    if (RELOCATE) begin : g_reloc
      assign vecRoot = vecBase;
    end else begin : g_fixed
      assign vecRoot = PC_W'(DEF_VECBASE);
    end
  endgenerate

  always_comb begin
    if (ctrl.hiLevel) begin
      kindNow  = KIND_HIGH;
      vecOff   = PC_W'(HI_OFF) + PC_W'(pendLevel) * PC_W'(HI_STRIDE);
      pcDstNow = pendLevel;
    end else if (ctrl.dbl) begin
      kindNow  = KIND_DOUBLE;
      vecOff   = PC_W'(DOUBLE_OFF);
      pcDstNow = DST_DOUBLE;
    end else if (ctrl.user) begin
      kindNow  = KIND_USER;
      vecOff   = PC_W'(USER_OFF);
      pcDstNow = LVL_W'(1);
    end else begin
      kindNow  = KIND_KERNEL;
      vecOff   = PC_W'(KERNEL_OFF);
      pcDstNow = LVL_W'(1);
    end
    vecAddr = vecRoot + vecOff;

    psHi                 = statusIn;
    psHi[LVL_W-1:0]      = pendLevel;
    psHi[EXCM_BIT]       = 1'b1;
    psL1                 = statusIn;
    psL1[EXCM_BIT]       = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excTaken  <= 1'b0;
      excKind   <= 2'd0;
      nextPc    <= '0;
      newStatus <= '0;
      savePcWe  <= 1'b0;
      savePcDst <= '0;
      savePcVal <= '0;
      savePsWe  <= 1'b0;
      savePsIdx <= '0;
      savePsVal <= '0;
      causeWe   <= 1'b0;
      causeVal  <= '0;
    end else begin
      excTaken <= ctrl.take;
      savePcWe <= ctrl.take;
      savePsWe <= ctrl.take && ctrl.hiLevel;
      causeWe  <= ctrl.take && !ctrl.hiLevel;
      if (ctrl.take) begin
        excKind   <= kindNow;
        nextPc    <= vecAddr;
        newStatus <= ctrl.hiLevel ? psHi : psL1;
        savePcDst <= pcDstNow;
        savePcVal <= pcIn;
        if (ctrl.hiLevel) begin
          savePsIdx <= pendLevel;
          savePsVal <= statusIn;
        end else begin
          causeVal <= CAUSE_W'(L1_CAUSE);
        end
      end else begin
        nextPc    <= pcIn;
        newStatus <= statusIn;
      end
    end
  end

endmodule

// File: rtl/dispatch_unit.sv
module dispatch_unit
  import dispatch_pkg::*;
#(
  parameter int          LVL_W       = 4,
  parameter int          PS_W        = 8,
  parameter int          PC_W        = 32,
  parameter int          NINT        = 16,
  parameter int          CAUSE_W     = 6,
  parameter int          NUM_LEVELS  = 6,
  parameter bit          RELOCATE    = 1'b1,
  parameter bit          HAS_DEPC    = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'h4000_0000
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            evalReq,
  input  logic [LVL_W-1:0]                pendLevel,
  input  logic [PS_W-1:0]                 statusIn,
  input  logic [PC_W-1:0]                 pcIn,
  input  logic [PC_W-1:0]                 vecBase,
  input  logic [NINT-1:0]                 intSet,
  input  logic [NINT-1:0]                 intEnable,
  input  logic [(2**LVL_W)-1:0][NINT-1:0] levelMask,
  output logic                            excTaken,
  output logic [1:0]                      excKind,
  output logic [PC_W-1:0]                 nextPc,
  output logic [PS_W-1:0]                 newStatus,
  output logic                            savePcWe,
  output logic [LVL_W-1:0]                savePcDst,
  output logic [PC_W-1:0]                 savePcVal,
  output logic                            savePsWe,
  output logic [LVL_W-1:0]                savePsIdx,
  output logic [PS_W-1:0]                 savePsVal,
  output logic                            causeWe,
  output logic [CAUSE_W-1:0]              causeVal
);

  dispCtrl_t ctrl;

  dispatch_ctrl #(
    .LVL_W(LVL_W), .PS_W(PS_W), .NINT(NINT), .NUM_LEVELS(NUM_LEVELS)
  ) u_ctrl (
    .evalReq(evalReq), .pendLevel(pendLevel), .statusIn(statusIn),
    .intSet(intSet), .intEnable(intEnable), .levelMask(levelMask),
    .ctrl(ctrl)
  );

  dispatch_dp #(
    .LVL_W(LVL_W), .PS_W(PS_W), .PC_W(PC_W), .CAUSE_W(CAUSE_W),
    .RELOCATE(RELOCATE), .HAS_DEPC(HAS_DEPC), .DEF_VECBASE(DEF_VECBASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pendLevel(pendLevel),
    .statusIn(statusIn), .pcIn(pcIn), .vecBase(vecBase),
    .excTaken(excTaken), .excKind(excKind), .nextPc(nextPc),
    .newStatus(newStatus), .savePcWe(savePcWe), .savePcDst(savePcDst),
    .savePcVal(savePcVal), .savePsWe(savePsWe), .savePsIdx(savePsIdx),
    .savePsVal(savePsVal), .causeWe(causeWe), .causeVal(causeVal)
  );

endmodule

// File: rtl/dispatch_unit_chk.sv
module dispatch_unit_chk #(
  parameter int LVL_W      = 4,
  parameter int PS_W       = 8,
  parameter int PC_W       = 32,
  parameter int NINT       = 16,
  parameter int CAUSE_W    = 6,
  parameter int NUM_LEVELS = 6
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            evalReq,
  input logic [LVL_W-1:0]                pendLevel,
  input logic [PS_W-1:0]                 statusIn,
  input logic [PC_W-1:0]                 pcIn,
  input logic [NINT-1:0]                 intSet,
  input logic [NINT-1:0]                 intEnable,
  input logic [(2**LVL_W)-1:0][NINT-1:0] levelMask,
  input logic                            excTaken,
  input logic [PC_W-1:0]                 nextPc,
  input logic [PS_W-1:0]                 newStatus,
  input logic                            savePcWe,
  input logic                            savePsWe,
  input logic                            causeWe
);

  p_level_above_r1: assert property (@(posedge clk) disable iff (!rstN)
    (evalReq && pendLevel <= statusIn[LVL_W-1:0]) |=> !excTaken);

  p_level_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evalReq && pendLevel > LVL_W'(NUM_LEVELS)) |=> !excTaken);

  p_src_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evalReq && ((levelMask[pendLevel] & intSet & intEnable) == '0)) |=> !excTaken);

  p_excm_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> newStatus[LVL_W]);

  p_pulse_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> ($past(evalReq) && savePcWe));

  p_no_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    !excTaken |-> (!savePcWe && !savePsWe && !causeWe));

  p_hold_pc_r12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !excTaken) |-> (nextPc == $past(pcIn) && newStatus == $past(statusIn)));

endmodule

bind dispatch_unit dispatch_unit_chk #(
  .LVL_W(LVL_W), .PS_W(PS_W), .PC_W(PC_W), .NINT(NINT),
  .CAUSE_W(CAUSE_W), .NUM_LEVELS(NUM_LEVELS)
) u_chk (
  .clk(clk), .rstN(rstN), .evalReq(evalReq), .pendLevel(pendLevel),
  .statusIn(statusIn), .pcIn(pcIn), .intSet(intSet), .intEnable(intEnable),
  .levelMask(levelMask), .excTaken(excTaken), .nextPc(nextPc),
  .newStatus(newStatus), .savePcWe(savePcWe), .savePsWe(savePsWe),
  .causeWe(causeWe)
);

// File: tb/sim_dispatch_unit.sv
module sim_dispatch_unit;

  localparam int LVL_W = 4, PS_W = 8, PC_W = 32, NINT = 16, CAUSE_W = 6, NUM_LEVELS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evalReq = 1'b0;
  logic [LVL_W-1:0] pendLevel = '0;
  logic [PS_W-1:0] statusIn = '0;
  logic [PC_W-1:0] pcIn = '0;
  logic [PC_W-1:0] vecBase = 32'h4000_0000;
  logic [NINT-1:0] intSet = '0;
  logic [NINT-1:0] intEnable = '0;
  logic [(2**LVL_W)-1:0][NINT-1:0] levelMask;

  logic excTaken, savePcWe, savePsWe, causeWe;
  logic [1:0] excKind;
  logic [PC_W-1:0] nextPc, savePcVal;
  logic [PS_W-1:0] newStatus, savePsVal;
  logic [LVL_W-1:0] savePcDst, savePsIdx;
  logic [CAUSE_W-1:0] causeVal;

  int nVec = 0;
  int nBad = 0;

  // reference state (expected output values)
  int eTaken = 0, eKind = 0, eNext = 0, ePs = 0, ePcWe = 0, ePcDst = 0, ePcVal = 0;
  int ePsWe = 0, ePsIdx = 0, ePsVal = 0, eCWe = 0, eCVal = 0;

  always #5 clk = ~clk;

  dispatch_unit u0 (
    .clk(clk), .rstN(rstN), .evalReq(evalReq), .pendLevel(pendLevel),
    .statusIn(statusIn), .pcIn(pcIn), .vecBase(vecBase), .intSet(intSet),
    .intEnable(intEnable), .levelMask(levelMask), .excTaken(excTaken),
    .excKind(excKind), .nextPc(nextPc), .newStatus(newStatus),
    .savePcWe(savePcWe), .savePcDst(savePcDst), .savePcVal(savePcVal),
    .savePsWe(savePsWe), .savePsIdx(savePsIdx), .savePsVal(savePsVal),
    .causeWe(causeWe), .causeVal(causeVal)
  );

  task automatic cmp(string tag, string fld, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    cmp(tag, "excTaken", int'(excTaken), eTaken);
    cmp(tag, "excKind", int'(excKind), eKind);
    cmp(tag, "nextPc", int'(nextPc), eNext);
    cmp(tag, "newStatus", int'(newStatus), ePs);
    cmp(tag, "savePcWe", int'(savePcWe), ePcWe);
    cmp(tag, "savePcDst", int'(savePcDst), ePcDst);
    cmp(tag, "savePcVal", int'(savePcVal), ePcVal);
    cmp(tag, "savePsWe", int'(savePsWe), ePsWe);
    cmp(tag, "savePsIdx", int'(savePsIdx), ePsIdx);
    cmp(tag, "savePsVal", int'(savePsVal), ePsVal);
    cmp(tag, "causeWe", int'(causeWe), eCWe);
    cmp(tag, "causeVal", int'(causeVal), eCVal);
  endtask

  // Behavioural prediction from the requirements
  task automatic predict();
    int lvl, cur, ps, pc;
    bit ok;
    lvl = int'(pendLevel);
    ps  = int'(statusIn);
    pc  = int'(pcIn);
    cur = ps & 15;
    ok  = evalReq && (lvl > cur) && (lvl <= NUM_LEVELS) &&
          ((levelMask[lvl] & intSet & intEnable) != 0);
    eTaken = ok; ePcWe = ok; ePsWe = 0; eCWe = 0;
    if (!ok) begin
      eNext = pc; ePs = ps;
    end else if (lvl > 1) begin
      eKind = 0; eNext = int'(vecBase) + 'h100 + lvl * 'h40;
      ePs = (ps & ~15) | lvl | 16;
      ePcDst = lvl; ePcVal = pc; ePsWe = 1; ePsIdx = lvl; ePsVal = ps;
    end else begin
      eCWe = 1; eCVal = 4; ePs = ps | 16; ePcVal = pc;
      if ((ps & 16) != 0) begin
        eKind = 3; eNext = int'(vecBase) + 'h3C0; ePcDst = 0;
      end else if ((ps & 32) != 0) begin
        eKind = 2; eNext = int'(vecBase) + 'h340; ePcDst = 1;
      end else begin
        eKind = 1; eNext = int'(vecBase) + 'h300; ePcDst = 1;
      end
    end
  endtask

  task automatic step(string tag, bit req, int lvl, int ps, int pc);
    evalReq   = req;
    pendLevel = LVL_W'(lvl);
    statusIn  = PS_W'(ps);
    pcIn      = PC_W'(pc);
    predict();
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2**LVL_W; i++) levelMask[i] = NINT'(1) << i;
    intSet    = '1;
    intEnable = '1;
    repeat (3) @(negedge clk);
    compareAll("reset");
    rstN = 1'b1;

    // R1: level must exceed current interrupt level
    step("R1", 1, 2, 2, 'h1000);
    step("R1", 1, 3, 2, 'h1004);
    // R2: level beyond configured count
    step("R2", 1, 7, 0, 'h1008);
    step("R2", 1, 6, 5, 'h100C);
    // R3: source masked off by enable
    intEnable = 16'hFFFF & ~(16'h1 << 4);
    step("R3", 1, 4, 0, 'h1010);
    intEnable = '1;
    step("R3", 1, 4, 0, 'h1014);
    // R4 R5 R6: high level saves and vectors, spare bits kept
    step("R4", 1, 5, 'hC1, 'h2000);
    step("R5", 1, 2, 'h61, 'h2004);
    step("R6", 1, 6, 'h03, 'h2008);
    // R7 R9: level one, kernel and user
    step("R7", 1, 1, 'h00, 'h3000);
    step("R9", 1, 1, 'h20, 'h3004);
    // R8: level one during an exception, both user states
    step("R8", 1, 1, 'h10, 'h3008);
    step("R8", 1, 1, 'h30, 'h300C);
    // R10: relocation follows the live base
    vecBase = 32'h8000_0400;
    step("R10", 1, 3, 0, 'h4000);
    step("R10", 1, 1, 'h20, 'h4004);
    // R11: pulse falls when the request is gone
    step("R11", 1, 2, 0, 'h5000);
    step("R11", 0, 2, 0, 'h5004);
    // R12: idle cycles track pc and status
    step("R12", 0, 0, 'h45, 'h6000);
    step("R12", 1, 0, 'h00, 'h6004);
    // random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) vecBase = PC_W'($urandom) & ~PC_W'('hFFF);
      intSet    = NINT'($urandom);
      intEnable = NINT'($urandom) | NINT'($urandom);
      step("R1", 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 8)),
           int'($urandom_range(0, 255)) & ~12, int'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule